// File: doc/BRIEF.md
# Hysteresis Refill Controller for a Pixel FIFO

This block decides when to fetch more pixel data into a FIFO that a display output drains. It watches the FIFO fill level against two programmable marks. When the level falls to the lower mark, it starts a refill. It then issues whole-burst read requests until the fill level, including the data already requested but not yet arrived, reaches the upper mark. Between refills it raises an idle flag, so that the memory behind it can stay in self-refresh for longer.

The two marks share one 32-bit configuration word. The block checks the programmed pair against the FIFO depth and the burst length. An upper mark that the FIFO cannot reach is reported and clamped. A gap narrower than one burst is reported but still accepted. Mark changes made during a refill are held back until the next refill starts. The block also records a sticky underflow whenever the drain side reads from an empty FIFO.

Top module: `thrfetch_ctrl`

## Requirements
- R1: The configuration word is written with `cfg_wr`. The lower mark sits in bits 11:0 and the upper mark in bits 27:16; the other bits are ignored. After reset the marks are DEF_LO and DEF_HI.
- R2: While the block is idle and `enable` is high, a fill level at or below the lower mark starts a refill on the next clock edge. The first `burst_req` appears in the cycle after that edge.
- R3: Each `burst_req` cycle requests BURST beats. A request is made only while (fill level + outstanding beats) is below the effective upper mark, and only while DEPTH minus that sum is at least BURST. Each `wr_beat` retires one outstanding beat.
- R4: Once (fill level + outstanding) reaches the effective upper mark, requests stop. The block returns to idle one cycle after the outstanding count reaches zero.
- R5: `cfg_err` is high while the programmed upper mark exceeds DEPTH − BURST. In that case the effective upper mark is DEPTH − BURST.
- R6: `cfg_warn` is high while the programmed upper mark is less than the lower mark plus BURST. Refills still run with the programmed marks.
- R7: A `rd_req` while `fifo_level` is 0 sets `underflow` on the next edge. The flag stays set until a `uf_clr` cycle that has no new underflow in it; a set wins over a clear in the same cycle.
- R8: `fetch_idle` is high only when the block is neither refilling nor waiting for outstanding beats.
- R9: A mark write made during a refill does not change that refill. The new marks take effect once the block is idle again.
- R10: With `enable` low, no request is made and no refill starts. After reset the FIFO level is 0, so enabling the block starts a refill at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows refills and requests |
| cfg_wr | input | 1 | Writes the configuration word |
| cfg_wdata | input | 32 | Lower mark [11:0], upper mark [27:16] |
| fifo_level | input | $clog2(DEPTH+1) | Current FIFO fill level in beats |
| wr_beat | input | 1 | One requested beat was written into the FIFO |
| rd_req | input | 1 | Drain side reads one beat |
| uf_clr | input | 1 | Clears the sticky underflow flag |
| burst_req | output | 1 | Request one burst of BURST beats this cycle |
| fetch_idle | output | 1 | No refill active and no beats outstanding |
| cfg_err | output | 1 | Upper mark cannot be reached |
| cfg_warn | output | 1 | Mark gap is smaller than one burst |
| underflow | output | 1 | Sticky read-while-empty flag |

## Verification
The bench counts the bursts issued in each refill and compares the count with the count the marks imply. A controller that ignored in-flight beats would over-request, and one that stopped early would come up short. It programs an unreachable upper mark and expects the refill to end at DEPTH − BURST; a controller without the clamp would keep requesting, or hang with requests still pending. It rewrites the marks in the middle of a refill and expects the old upper mark to govern that refill and the new lower mark the next one. It also tests the priority of set over clear on the underflow flag, which a design with the wrong priority would lose.

// File: rtl/thrfetch_pkg.sv
package thrfetch_pkg;
    localparam int TW = 12;
    localparam int CW = TW + 2;

    typedef struct packed {
        logic [TW-1:0] hi;
        logic [TW-1:0] lo;
    } marks_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_WAIT = 2'd2
    } fstate_t;

    function automatic marks_t split_word(input logic [31:0] w);
        marks_t m;
        m.lo = w[11:0];
        m.hi = w[27:16];
        return m;
    endfunction

    function automatic logic [TW-1:0] clamp_mark(input logic [TW-1:0] v, input logic [TW-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction
endpackage

// File: rtl/thrfetch_marks.sv
module thrfetch_marks
    import thrfetch_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BURST  = 16,
    parameter int DEF_LO = 64,
    parameter int DEF_HI = 192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        load_frozen,
    input  logic        use_frozen,
    output marks_t      eff,
    output logic        cfg_err,
    output logic        cfg_warn
);
    localparam logic [TW-1:0] LIMIT = TW'(DEPTH - BURST);
    localparam marks_t RST_MARKS = '{hi: TW'(DEF_HI), lo: TW'(DEF_LO)};

    marks_t shadow_q, frozen_q, sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RST_MARKS;
            frozen_q <= RST_MARKS;
        end else begin
            if (cfg_wr)      shadow_q <= split_word(cfg_wdata);
            if (load_frozen) frozen_q <= shadow_q;
        end
    end

    always_comb begin
        sel    = use_frozen ? frozen_q : shadow_q;
        eff.lo = sel.lo;
        eff.hi = clamp_mark(sel.hi, LIMIT);
    end

    assign cfg_err  = shadow_q.hi > LIMIT;
    assign cfg_warn = {1'b0, shadow_q.hi} < ({1'b0, shadow_q.lo} + (TW+1)'(BURST));
endmodule

// File: rtl/thrfetch_fsm.sv
module thrfetch_fsm
    import thrfetch_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int BURST = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             wr_beat,
    input  marks_t           eff,
    output logic             burst_req,
    output logic             fetch_idle,
    output logic             load_frozen,
    output logic             use_frozen,
    output logic [CW-1:0]    outstanding
);
    fstate_t       st_q, st_d;
    logic [CW-1:0] out_q, out_d, lvl_x, proj;
    logic          below_hi, has_room, retire;

    always_comb begin
        lvl_x    = CW'(fifo_level);
        proj     = lvl_x + out_q;
        below_hi = proj < CW'(eff.hi);
        has_room = (proj + CW'(BURST)) <= CW'(DEPTH);
        burst_req = (st_q == ST_FILL) && enable && below_hi && has_room;
        retire   = wr_beat && (out_q != '0);
        out_d    = out_q + (burst_req ? CW'(BURST) : '0) - (retire ? CW'(1) : '0);

        st_d = st_q;
        case (st_q)
            ST_IDLE: if (enable && (lvl_x <= CW'(eff.lo))) st_d = ST_FILL;
            ST_FILL: if (!enable || !below_hi)              st_d = ST_WAIT;
            ST_WAIT: if (out_q == '0)                       st_d = ST_IDLE;
            default:                                        st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
        end
    end

    assign load_frozen = (st_q == ST_IDLE) && (st_d == ST_FILL);
    assign use_frozen  = (st_q != ST_IDLE);
    assign fetch_idle  = (st_q == ST_IDLE);
    assign outstanding = out_q;
endmodule

// File: rtl/thrfetch_uflag.sv
module thrfetch_uflag #(
    parameter int LVL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             uf_clr,
    output logic             underflow
);
    logic hit;
    assign hit = rd_req && (fifo_level == '0);

    always_ff @(posedge clk) begin
        if (rst)         underflow <= 1'b0;
        else if (hit)    underflow <= 1'b1;
        else if (uf_clr) underflow <= 1'b0;
    end
endmodule

// File: rtl/thrfetch_ctrl.sv
module thrfetch_ctrl
    import thrfetch_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BURST  = 16,
    parameter int DEF_LO = 64,
    parameter int DEF_HI = 192,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             wr_beat,
    input  logic             rd_req,
    input  logic             uf_clr,
    output logic             burst_req,
    output logic             fetch_idle,
    output logic             cfg_err,
    output logic             cfg_warn,
    output logic             underflow
);
    marks_t        eff;
    logic          load_frozen, use_frozen;
    logic [CW-1:0] outstanding;

    thrfetch_marks #(.DEPTH(DEPTH), .BURST(BURST), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_marks (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .load_frozen(load_frozen), .use_frozen(use_frozen),
        .eff(eff), .cfg_err(cfg_err), .cfg_warn(cfg_warn)
    );

    thrfetch_fsm #(.DEPTH(DEPTH), .BURST(BURST)) u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .fifo_level(fifo_level),
        .wr_beat(wr_beat), .eff(eff), .burst_req(burst_req),
        .fetch_idle(fetch_idle), .load_frozen(load_frozen),
        .use_frozen(use_frozen), .outstanding(outstanding)
    );

    thrfetch_uflag #(.LVL_W(LVL_W)) u_uflag (
        .clk(clk), .rst(rst), .rd_req(rd_req), .fifo_level(fifo_level),
        .uf_clr(uf_clr), .underflow(underflow)
    );
endmodule

// File: rtl/thrfetch_chk.sv
module thrfetch_chk
    import thrfetch_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int BURST = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             cfg_wr,
    input logic [31:0]      cfg_wdata,
    input logic [LVL_W-1:0] fifo_level,
    input logic             rd_req,
    input logic             uf_clr,
    input logic             burst_req,
    input logic             fetch_idle,
    input logic             cfg_err,
    input logic             underflow,
    input logic [CW-1:0]    outstanding
);
    localparam logic [11:0] LIMIT = 12'(DEPTH - BURST);

    // R3: a request always fits in the free space left after in-flight beats
    p_req_room_r3: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> ((CW'(fifo_level) + outstanding + CW'(BURST)) <= CW'(DEPTH)));

    // R10: no request while disabled
    p_req_enable_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !burst_req);

    // R8: idle means no request and nothing in flight
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        fetch_idle |-> (!burst_req && (outstanding == '0)));

    // R7: read from empty FIFO sets the flag
    p_uf_set_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (fifo_level == '0)) |=> underflow);

    // R7: flag holds without a clear
    p_uf_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (underflow && !uf_clr) |=> underflow);

    // R5: writing an unreachable upper mark raises the error flag
    p_cfg_err_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && (cfg_wdata[27:16] > LIMIT)) |=> cfg_err);
endmodule

bind thrfetch_ctrl thrfetch_chk #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .fifo_level(fifo_level), .rd_req(rd_req), .uf_clr(uf_clr),
    .burst_req(burst_req), .fetch_idle(fetch_idle), .cfg_err(cfg_err),
    .underflow(underflow), .outstanding(outstanding)
);

// File: tb/tb_thrfetch_ctrl.sv
module tb_thrfetch_ctrl;
    localparam int DEPTH = 256;
    localparam int BURST = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [8:0]  lvl = '0;
    logic        wr_beat = 1'b0;
    logic        rd_req = 1'b0;
    logic        uf_clr = 1'b0;
    logic        burst_req, fetch_idle, cfg_err, cfg_warn, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {err, warn, hi, lo}: err when hi > 240, warn when hi < lo + 16
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 1'b0, 12'd96,   12'd32},
        {1'b0, 1'b0, 12'd240,  12'd0},
        {1'b1, 1'b0, 12'd241,  12'd0},
        {1'b0, 1'b1, 12'd110,  12'd100},
        {1'b0, 1'b0, 12'd116,  12'd100},
        {1'b1, 1'b0, 12'd4000, 12'd200},
        {1'b1, 1'b1, 12'd4095, 12'd4095},
        {1'b0, 1'b1, 12'd40,   12'd50}
    };

    thrfetch_ctrl #(.DEPTH(DEPTH), .BURST(BURST), .DEF_LO(64), .DEF_HI(192)) dut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .fifo_level(lvl), .wr_beat(wr_beat), .rd_req(rd_req), .uf_clr(uf_clr),
        .burst_req(burst_req), .fetch_idle(fetch_idle), .cfg_err(cfg_err),
        .cfg_warn(cfg_warn), .underflow(underflow)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int lo, input int hi);
        return {4'hA, 12'(hi), 4'h5, 12'(lo)};
    endfunction

    task automatic cfg_write(input int lo, input int hi);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = word(lo, hi);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // counts requests over n cycles; optionally writes marks in the first one
    task automatic count_req(input int n, input bit do_wr, input int lo, input int hi, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr = (do_wr && i == 0);
            cfg_wdata = word(lo, hi);
            #1;
            if (burst_req) cnt++;
        end
        cfg_wr = 1'b0;
    endtask

    task automatic ret_beats(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) lvl = lvl + 1'b1;
            wr_beat = 1'b1;
        end
        @(negedge clk);
        lvl = lvl + 1'b1;
        wr_beat = 1'b0;
    endtask

    task automatic step_check_idle(input string tag, input int exp);
        @(negedge clk);
        #1;
        check(tag, fetch_idle, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 reset idle", fetch_idle, 1);
        check("R10 reset no req", burst_req, 0);
        check("R5 reset err", cfg_err, 0);
        check("R6 reset warn", cfg_warn, 0);
        check("R7 reset underflow", underflow, 0);

        // R10: level 0 but disabled, nothing happens
        count_req(5, 1'b0, 0, 0, n);
        check("R10 disabled no req", n, 0);
        check("R10 disabled idle", fetch_idle, 1);

        // R1 R5 R6: flag table
        for (int v = 0; v < 8; v++) begin
            cfg_write(int'(VEC[v][11:0]), int'(VEC[v][23:12]));
            #1;
            check($sformatf("R5 table %0d", v), cfg_err, VEC[v][25]);
            check($sformatf("R6 R1 table %0d", v), cfg_warn, VEC[v][24]);
        end

        // R2 R3 R4: refill from empty, lo=32 hi=96 -> 6 bursts
        cfg_write(32, 96);
        @(negedge clk);
        enable = 1'b1;
        count_req(20, 1'b0, 0, 0, n);
        check("R2 R3 bursts from empty", n, 6);
        check("R8 waiting not idle", fetch_idle, 0);
        ret_beats(96);
        check("R4 still waiting at last beat", fetch_idle, 0);
        step_check_idle("R4 idle after drain", 1);

        // R9: write lo=16 hi=64 during refill, old hi=96 governs -> 4 bursts
        @(negedge clk);
        lvl = 9'd32;
        count_req(20, 1'b1, 16, 64, n);
        check("R9 old marks during refill", n, 4);
        ret_beats(64);
        step_check_idle("R9 idle after refill", 1);
        @(negedge clk);
        lvl = 9'd32;
        repeat (3) step_check_idle("R9 new low mark holds idle", 1);
        @(negedge clk);
        lvl = 9'd16;
        count_req(20, 1'b0, 0, 0, n);
        check("R9 new high mark", n, 3);
        ret_beats(48);
        step_check_idle("R4 idle", 1);

        // R5: unreachable hi=4000 clamps to 240 -> from 64, 11 bursts
        count_req(25, 1'b1, 200, 4000, n);
        check("R5 clamped bursts", n, 11);
        check("R5 err flag", cfg_err, 1);
        ret_beats(176);
        step_check_idle("R5 idle after clamp refill", 1);

        // R6: narrow gap still refills, one burst
        cfg_write(100, 110);
        #1;
        check("R6 warn flag", cfg_warn, 1);
        check("R6 no err", cfg_err, 0);
        @(negedge clk);
        lvl = 9'd100;
        count_req(10, 1'b0, 0, 0, n);
        check("R6 narrow gap bursts", n, 1);
        ret_beats(16);
        step_check_idle("R6 idle", 1);

        // R10: disable before crossing
        @(negedge clk);
        enable = 1'b0;
        lvl = 9'd50;
        count_req(6, 1'b0, 0, 0, n);
        check("R10 disabled crossing", n, 0);
        check("R10 disabled stays idle", fetch_idle, 1);

        // R7: underflow
        @(negedge clk);
        lvl = 9'd5;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        check("R7 read nonempty no flag", underflow, 0);
        lvl = 9'd0;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        check("R7 set", underflow, 1);
        repeat (3) @(negedge clk);
        #1;
        check("R7 sticky", underflow, 1);
        rd_req = 1'b1;
        uf_clr = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        check("R7 set beats clear", underflow, 1);
        @(negedge clk);
        uf_clr = 1'b0;
        #1;
        check("R7 cleared", underflow, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule